// File: doc/BRIEF.md
# Rising-Edge Interval Manchester Receiver

This block decodes a serial line that carries one bit per fixed time slot: a 1 is a low-to-high swing in the middle of its slot and a 0 is a high-to-low swing. Because the falling transitions of the line cannot be trusted, the receiver looks only at rising edges. It measures the number of clock cycles between two consecutive rising edges, sorts that count into one of three spans (one slot, one and a half slots, two slots), and turns each span into one or two bits. Which bits a span stands for depends on the last bit already decoded.

The line rests low between messages. The first rising edge after rest is taken as the leading 1 of a new message. Every message must close with two zeros. When the line then stays quiet for longer than any legal span, the message is over. The sender's slot length may drift. Each span therefore matches within a tolerance given in clock cycles, set at run time together with the nominal slot length.

Decoded bits leave as a serial stream with a one-cycle valid strobe. Alongside the stream the block gives a one-cycle pulse when a message opens, another when it closes, and a one-cycle error pulse.

Top module: `mrx_rx`

## Requirements
- R1: While reset is held and in the first cycle after it, bit_valid_o, bit_o, msg_start_o, msg_end_o and err_o are all 0.
- R2: A rising edge on line_i that arrives while the receiver is idle produces msg_start_o together with bit_valid_o=1 and bit_o=1 in a single cycle. The outputs appear after the third rising clock edge that samples the line high (two synchronizer stages plus one output register).
- R3: An interval of N cycles between rising edges belongs to a span when |N - target| <= slot_tol_i. The targets are slot_len_i, slot_len_i + floor(slot_len_i/2) and 2*slot_len_i. The bounds are inclusive.
- R4: When the last decoded bit is 1, a one-slot span decodes as 1, a one-and-a-half-slot span as 0,0 and a two-slot span as 0,1.
- R5: When the last decoded bit is 0, a one-slot span decodes as 0 and a one-and-a-half-slot span as 1. A two-slot span is an error.
- R6: A span that stands for two bits gives them on two consecutive cycles, the earlier bit first. Its first bit comes out in the cycle in which a single-bit span's bit would come out.
- R7: During a message, if no rising edge follows the last one for more than 2*slot_len_i + floor(slot_len_i/2) cycles, msg_end_o pulses for one cycle with no bit. The receiver then returns to idle.
- R8: If the last two decoded bits at the close of a message are not 0,0, err_o pulses in the same cycle as msg_end_o.
- R9: An interval that fits no allowed span raises err_o for one cycle with no bit and no msg_end_o. The receiver then ignores rising edges until the line has been free of them for more than the end-of-message limit, and becomes idle again without an end pulse.
- R10: The interval counter stops at 2^CNT_W-1 and does not wrap. An idle gap longer than that range leaves no trace on the outputs.
- R11: A sender whose half-slots are shorter or longer than nominal is decoded exactly, as long as every span stays within the tolerance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Serial line, resynchronized inside |
| slot_len_i | input | CNT_W | Nominal slot length in clock cycles |
| slot_tol_i | input | CNT_W | Allowed deviation of each span in clock cycles |
| bit_o | output | 1 | Decoded bit |
| bit_valid_o | output | 1 | bit_o carries a bit this cycle |
| msg_start_o | output | 1 | Pulse: a message has started |
| msg_end_o | output | 1 | Pulse: a message has ended |
| err_o | output | 1 | Pulse: bad span or bad trailer |

## Verification
The close of a message and the error flag can land in one cycle. This happens when the quiet-line timeout fires after a message whose last two bits are not zeros. The bench provokes it by sending a message that ends in 0,1 and letting the line rest. Its behavioural model predicts end and error together in that exact cycle, and a message-level count of cycles holding both pulses must come to one. The leading-bit strobe shares its cycle with the start pulse in the same way. This coincidence is checked on every cycle against the model and by a property.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HUNT = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        SPAN_NONE = 2'd0,
        SPAN_ONE  = 2'd1,
        SPAN_HALF = 2'd2,
        SPAN_TWO  = 2'd3
    } span_e;

    typedef struct packed {
        rx_state_e  st;
        logic [1:0] last2;     // [0] newest decoded bit, [1] the one before
        logic       pend;      // second bit of a pair still to be sent
        logic       pend_bit;
        logic       bit_d;
        logic       bit_v;
        logic       start;
        logic       fin;
        logic       err;
    } rx_reg_t;

endpackage

// File: rtl/mrx_sync.sv
module mrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_i,
    output logic rise_o
);

    typedef struct packed {
        logic [STAGES:0] sh;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.sh = {sync_q.sh[STAGES-1:0], line_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    // last synchronized stage high, extra history stage still low
    assign rise_o = sync_q.sh[STAGES-1] & ~sync_q.sh[STAGES];

endmodule

// File: rtl/mrx_interval.sv
module mrx_interval #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             restart_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ivl_t;

    ivl_t ivl_d, ivl_q;

    always_comb begin
        ivl_d = ivl_q;
        if (restart_i)                ivl_d.cnt = CNT_ONE;
        else if (ivl_q.cnt != CNT_MAX) ivl_d.cnt = ivl_q.cnt + CNT_ONE;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ivl_q <= '0;
        else         ivl_q <= ivl_d;
    end

    assign cnt_o = ivl_q.cnt;

endmodule

// File: rtl/mrx_classify.sv
module mrx_classify
    import mrx_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] slot_i,
    input  logic [CNT_W-1:0] tol_i,
    output span_e            span_o,
    output logic             quiet_o
);

    localparam int WW = CNT_W + 2;

    logic [WW-1:0] cnt_w, tol_w, one_w, half_w, two_w, lim_w;

    function automatic logic near(input logic [WW-1:0] a,
                                  input logic [WW-1:0] b,
                                  input logic [WW-1:0] t);
        logic [WW-1:0] diff;
        diff = (a >= b) ? (a - b) : (b - a);
        return diff <= t;
    endfunction

    always_comb begin
        cnt_w  = {2'b00, cnt_i};
        tol_w  = {2'b00, tol_i};
        one_w  = {2'b00, slot_i};
        half_w = one_w + {3'b000, slot_i[CNT_W-1:1]};
        two_w  = {1'b0, slot_i, 1'b0};
        lim_w  = two_w + {3'b000, slot_i[CNT_W-1:1]};

        if (near(cnt_w, one_w, tol_w))       span_o = SPAN_ONE;
        else if (near(cnt_w, half_w, tol_w)) span_o = SPAN_HALF;
        else if (near(cnt_w, two_w, tol_w))  span_o = SPAN_TWO;
        else                                 span_o = SPAN_NONE;

        quiet_o = cnt_w > lim_w;
    end

endmodule

// File: rtl/mrx_rx.sv
module mrx_rx
    import mrx_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             line_i,
    input  logic [CNT_W-1:0] slot_len_i,
    input  logic [CNT_W-1:0] slot_tol_i,
    output logic             bit_o,
    output logic             bit_valid_o,
    output logic             msg_start_o,
    output logic             msg_end_o,
    output logic             err_o
);

    logic             rise;
    logic [CNT_W-1:0] span_cnt;
    span_e            span;
    logic             quiet;

    rx_reg_t state_d, state_q;

    mrx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .line_i (line_i),
        .rise_o (rise)
    );

    mrx_interval #(.CNT_W(CNT_W)) i_interval (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (rise),
        .cnt_o     (span_cnt)
    );

    mrx_classify #(.CNT_W(CNT_W)) i_classify (
        .cnt_i   (span_cnt),
        .slot_i  (slot_len_i),
        .tol_i   (slot_tol_i),
        .span_o  (span),
        .quiet_o (quiet)
    );

    always_comb begin
        state_d       = state_q;
        state_d.bit_v = 1'b0;
        state_d.bit_d = 1'b0;
        state_d.start = 1'b0;
        state_d.fin   = 1'b0;
        state_d.err   = 1'b0;
        state_d.pend  = 1'b0;

        // second half of a two-bit group
        if (state_q.pend) begin
            state_d.bit_v = 1'b1;
            state_d.bit_d = state_q.pend_bit;
            state_d.last2 = {state_q.last2[0], state_q.pend_bit};
        end

        unique case (state_q.st)
            ST_IDLE: begin
                if (rise) begin
                    state_d.start = 1'b1;
                    state_d.bit_v = 1'b1;
                    state_d.bit_d = 1'b1;
                    state_d.last2 = 2'b01;
                    state_d.st    = ST_RUN;
                end
            end
            ST_RUN: begin
                if (rise) begin
                    if (state_q.last2[0]) begin
                        unique case (span)
                            SPAN_ONE: begin
                                state_d.bit_v = 1'b1;
                                state_d.bit_d = 1'b1;
                                state_d.last2 = {state_q.last2[0], 1'b1};
                            end
                            SPAN_HALF, SPAN_TWO: begin
                                state_d.bit_v    = 1'b1;
                                state_d.bit_d    = 1'b0;
                                state_d.last2    = {state_q.last2[0], 1'b0};
                                state_d.pend     = 1'b1;
                                state_d.pend_bit = (span == SPAN_TWO);
                            end
                            default: begin
                                state_d.err = 1'b1;
                                state_d.st  = ST_HUNT;
                            end
                        endcase
                    end else begin
                        unique case (span)
                            SPAN_ONE: begin
                                state_d.bit_v = 1'b1;
                                state_d.bit_d = 1'b0;
                                state_d.last2 = {state_q.last2[0], 1'b0};
                            end
                            SPAN_HALF: begin
                                state_d.bit_v = 1'b1;
                                state_d.bit_d = 1'b1;
                                state_d.last2 = {state_q.last2[0], 1'b1};
                            end
                            default: begin
                                state_d.err = 1'b1;
                                state_d.st  = ST_HUNT;
                            end
                        endcase
                    end
                end else if (quiet) begin
                    state_d.fin = 1'b1;
                    state_d.err = (state_q.last2 != 2'b00);
                    state_d.st  = ST_IDLE;
                end
            end
            ST_HUNT: begin
                if (!rise && quiet) state_d.st = ST_IDLE;
            end
            default: state_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q    <= '0;
            state_q.st <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign bit_o       = state_q.bit_d;
    assign bit_valid_o = state_q.bit_v;
    assign msg_start_o = state_q.start;
    assign msg_end_o   = state_q.fin;
    assign err_o       = state_q.err;

endmodule

// File: rtl/mrx_rx_chk.sv
module mrx_rx_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             bit_o,
    input logic             bit_valid_o,
    input logic             msg_start_o,
    input logic             msg_end_o,
    input logic             err_o,
    input logic             run_i,
    input logic             rise_i,
    input logic [CNT_W-1:0] cnt_i
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assert_start_bit_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        msg_start_o |-> (bit_valid_o && bit_o));

    assert_end_no_bit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        msg_end_o |-> (!bit_valid_o && !msg_start_o));

    assert_end_from_run_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        msg_end_o |-> $past(run_i));

    assert_err_not_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> (!msg_start_o && !bit_valid_o));

    assert_no_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_i == CNT_MAX && !rise_i) |=> (cnt_i == CNT_MAX));

endmodule

bind mrx_rx mrx_rx_chk #(.CNT_W(CNT_W)) i_mrx_rx_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_o       (bit_o),
    .bit_valid_o (bit_valid_o),
    .msg_start_o (msg_start_o),
    .msg_end_o   (msg_end_o),
    .err_o       (err_o),
    .run_i       (state_q.st == mrx_pkg::ST_RUN),
    .rise_i      (rise),
    .cnt_i       (span_cnt)
);

// File: tb/test_mrx_rx.sv
`timescale 1ns/1ps
module test_mrx_rx;

    localparam int CW   = 8;
    localparam int SLOT = 20;
    localparam int TOL  = 4;
    localparam int LIM  = 2*SLOT + SLOT/2;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line = 1'b0;
    logic [CW-1:0] slot = CW'(SLOT);
    logic [CW-1:0] tol  = CW'(TOL);
    logic bit_o, bit_valid_o, msg_start_o, msg_end_o, err_o;

    always #2 clk = ~clk;

    mrx_rx #(.CNT_W(CW)) i_mrx_rx (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .line_i      (line),
        .slot_len_i  (slot),
        .slot_tol_i  (tol),
        .bit_o       (bit_o),
        .bit_valid_o (bit_valid_o),
        .msg_start_o (msg_start_o),
        .msg_end_o   (msg_end_o),
        .err_o       (err_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic h1, h2, h3;
    int   since, mst, lb0, lb1;
    int   q_exp[$];
    logic e_bit, e_vld, e_start, e_end, e_err;

    function automatic int span_of(input int n);
        if ((n - SLOT <= TOL) && (SLOT - n <= TOL)) return 1;
        if ((n - (SLOT + SLOT/2) <= TOL) && ((SLOT + SLOT/2) - n <= TOL)) return 3;
        if ((n - 2*SLOT <= TOL) && (2*SLOT - n <= TOL)) return 4;
        return 0;
    endfunction

    task automatic add_bit(input int b);
        q_exp.push_back(b);
        lb1 = lb0;
        lb0 = b;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h1 = 0; h2 = 0; h3 = 0;
            since = 0; mst = 0; lb0 = 0; lb1 = 0;
            q_exp.delete();
            e_bit = 0; e_vld = 0; e_start = 0; e_end = 0; e_err = 0;
        end else begin : step
            logic r;
            int   sp;
            r  = h2 & ~h3;
            h3 = h2; h2 = h1; h1 = line;
            e_start = 0; e_end = 0; e_err = 0;
            sp = span_of(since);
            if (mst == 0) begin
                if (r) begin
                    e_start = 1;
                    add_bit(1);
                    mst = 1;
                end
            end else if (mst == 1) begin
                if (r) begin
                    if (lb0 == 1) begin
                        if (sp == 1)      add_bit(1);
                        else if (sp == 3) begin add_bit(0); add_bit(0); end
                        else if (sp == 4) begin add_bit(0); add_bit(1); end
                        else begin e_err = 1; mst = 2; end
                    end else begin
                        if (sp == 1)      add_bit(0);
                        else if (sp == 3) add_bit(1);
                        else begin e_err = 1; mst = 2; end
                    end
                end else if (since > LIM) begin
                    e_end = 1;
                    e_err = !(lb0 == 0 && lb1 == 0);
                    mst = 0;
                end
            end else begin
                if (!r && since > LIM) mst = 0;
            end
            since = r ? 1 : ((since < CMAX) ? since + 1 : CMAX);
            if (q_exp.size() > 0) begin
                e_vld = 1;
                e_bit = q_exp.pop_front() != 0;
            end else begin
                e_vld = 0;
                e_bit = 0;
            end
        end
    end

    // ---------------- monitor ----------------
    int got[$];
    int n_start, n_end, n_err, n_both;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(bit_valid_o == e_vld, "R6 cycle model bit_valid", bit_valid_o, e_vld);
            check(bit_o == e_bit, "R4 cycle model bit", bit_o, e_bit);
            check(msg_start_o == e_start, "R2 cycle model start", msg_start_o, e_start);
            check(msg_end_o == e_end, "R7 cycle model end", msg_end_o, e_end);
            check(err_o == e_err, "R9 cycle model err", err_o, e_err);
            if (bit_valid_o) got.push_back(int'(bit_o));
            if (msg_start_o) n_start++;
            if (msg_end_o)   n_end++;
            if (err_o)       n_err++;
            if (msg_end_o && err_o) n_both++;
        end
    end

    // ---------------- transmitter ----------------
    task automatic hold(input logic v, input int n);
        line = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic tx_bits(input int b[$], input int half);
        foreach (b[i]) begin
            if (b[i] != 0) begin hold(1'b0, half); hold(1'b1, half); end
            else           begin hold(1'b1, half); hold(1'b0, half); end
        end
    endtask

    task automatic clear();
        got.delete();
        n_start = 0; n_end = 0; n_err = 0; n_both = 0;
    endtask

    task automatic judge(input string req, input int exp_bits[$],
                         input int s, input int e, input int er, input int both);
        check(got.size() == exp_bits.size(), {req, " bit count"}, got.size(), exp_bits.size());
        foreach (exp_bits[i])
            if (i < got.size())
                check(got[i] == exp_bits[i], {req, " bit value"}, got[i], exp_bits[i]);
        check(n_start == s, {req, " start pulses"}, n_start, s);
        check(n_end == e, {req, " end pulses"}, n_end, e);
        check(n_err == er, {req, " error pulses"}, n_err, er);
        check(n_both == both, {req, " end with error"}, n_both, both);
    endtask

    initial begin : main
        int m[$];
        repeat (5) @(negedge clk);
        // R1: outputs quiet under reset
        check({bit_o, bit_valid_o, msg_start_o, msg_end_o, err_o} == 5'b0, "R1 in reset", 
              int'({bit_o, bit_valid_o, msg_start_o, msg_end_o, err_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({bit_o, bit_valid_o, msg_start_o, msg_end_o, err_o} == 5'b0, "R1 after reset",
              int'({bit_o, bit_valid_o, msg_start_o, msg_end_o, err_o}), 0);
        hold(1'b0, 10);

        // R2 R4 R7: shortest legal message, 1.5-slot span after a 1
        clear(); m = '{1, 0, 0};
        tx_bits(m, 10); hold(1'b0, 100);
        judge("R2 R4 R7 short message", m, 1, 1, 0, 0);

        // R4 R5 R6 R11: fast sender
        clear(); m = '{1, 1, 0, 1, 0, 0, 0};
        tx_bits(m, 9); hold(1'b0, 100);
        judge("R5 R6 R11 fast sender", m, 1, 1, 0, 0);

        // R3 R5 R11: slow sender, two-slot span exactly at the tolerance edge
        clear(); m = '{1, 0, 1, 1, 0, 0, 1, 0, 0};
        tx_bits(m, 11); hold(1'b0, 100);
        judge("R3 R11 slow sender", m, 1, 1, 0, 0);

        // R8: trailer 0,1 -> end and error together
        clear(); m = '{1, 0, 1};
        tx_bits(m, 10); hold(1'b0, 100);
        judge("R8 bad trailer", m, 1, 1, 1, 1);

        // R3 R9: interval of 25 lies between the one and 1.5 slot windows
        clear(); m = '{1};
        hold(1'b1, 10); hold(1'b0, 15); hold(1'b1, 10); hold(1'b0, 100);
        judge("R3 R9 runt span", m, 1, 0, 1, 0);

        // R5 R9: two-slot span after a 0 is illegal
        clear(); m = '{1, 0, 0};
        tx_bits(m, 10); hold(1'b0, 20); hold(1'b1, 10); hold(1'b0, 100);
        judge("R5 R9 two slots after zero", m, 1, 0, 1, 0);

        // R10: idle longer than the counter range, then a clean message
        clear(); m = '{};
        hold(1'b0, 600);
        judge("R10 long idle", m, 0, 0, 0, 0);
        clear(); m = '{1, 1, 0, 0};
        tx_bits(m, 10); hold(1'b0, 100);
        judge("R10 message after long idle", m, 1, 1, 0, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule